// File: doc/BRIEF.md
# Fixed-Point Integer Unit with Condition Code and Branch Decision

This block is a 32-bit two's-complement integer unit. Each accepted operation is registered on the next rising clock edge. The operation writes a result register and a 2-bit condition code. It can also raise a one-cycle overflow interrupt request. Supported operations are signed and logical add and subtract, signed and logical compare, four loads (test, complement, positive, negative), bitwise AND, OR and XOR, and a test of selected bits.

A separate branch evaluator is combinational. It compares a 4-bit branch mask with the condition code currently held and reports whether a conditional branch would be taken. Each operation class maps its outcomes onto the four code values in its own way. A branch tests the mask against the code, so software can branch on any subset of outcomes.

Opcode encoding (opCode): 0 signed add, 1 signed subtract, 2 logical add, 3 logical subtract, 4 signed compare, 5 logical compare, 6 load and test, 7 load complement, 8 load positive, 9 load negative, 10 AND, 11 OR, 12 XOR, 13 test selected bits. Codes 14 and 15 are undefined. The four loads take their operand from opB.

Top module: `fxu_top`

## Requirements
- R1: While rstN is low, and on the first edge after it rises, result is 0, ccOut is 0 and ovfIrq is 0.
- R2: Signed add (0) and subtract (1) write opA+opB or opA-opB modulo 2^32 one edge after opValid. ccOut is 0 for a zero result, 1 for negative, 2 for positive and 3 on signed overflow.
- R3: Logical add (2) and subtract (3) write the modulo-2^32 sum or difference. The subtract is formed as opA + ~opB + 1. ccOut bit 1 is the carry out of bit 31, and ccOut bit 0 is 1 when the result is nonzero.
- R4: Signed compare (4) and logical compare (5) set ccOut to 0 when opA equals opB, 1 when opA is lower and 2 when opA is higher. They leave result unchanged.
- R5: Load and test (6) writes opB with code 0/1/2 by zero/negative/positive. Load complement (7) writes -opB with code 0/1/2/3. Load positive (8) writes |opB| with code 0/2/3. Load negative (9) writes -|opB| with code 0/1. For 0x80000000, load complement and load positive return 0x80000000 with code 3.
- R6: AND (10), OR (11) and XOR (12) write the bitwise result and set ccOut to 0 when it is zero, 1 otherwise.
- R7: Test selected bits (13) uses opB[7:0] as a mask over opA[7:0]. ccOut is 0 when the selected bits are all zero or the mask is zero, 3 when all are one, and 1 when mixed. result is unchanged.
- R8: Opcodes 14 and 15, and cycles with opValid low, leave both result and ccOut unchanged.
- R9: On overflow from opcodes 0, 1, 7 or 8, ovfIrq is 1 for exactly the following cycle if progMaskEn was 1 at the capturing edge. Otherwise ovfIrq stays 0 and only ccOut (3) records the overflow.
- R10: brTaken is brMask[3 - ccOut], combinationally from the current ccOut. Mask bit 3 selects code 0 and bit 0 selects code 3, so 4'hF always branches and 4'h0 never does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation select |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, load source, or test mask in bits 7:0 |
| progMaskEn | input | 1 | Enables the overflow interrupt request |
| brMask | input | 4 | Branch condition mask |
| result | output | 32 | Result register |
| ccOut | output | 2 | Condition code register |
| ovfIrq | output | 1 | Overflow interrupt request, one cycle |
| brTaken | output | 1 | Branch decision for the current code |

## Verification
The assertions take for granted that opCode, opA and progMaskEn are known whenever opValid is high. They also take for granted that brMask is held steady around the sampling point, so that the combinational branch decision is read only after settling. The bench drives every input on the falling edge and never leaves opValid or brMask unknown. It sweeps all fourteen operations over a grid of corner operands, including zero, one, all ones and both signed extremes, with both settings of the interrupt enable. It also walks all sixteen masks against each of the four code values.

// File: rtl/fxu_pkg.sv
package fxu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_ADDL = 4'd2,  OP_SUBL = 4'd3,
    OP_CMP  = 4'd4,  OP_CMPL = 4'd5,  OP_LTST = 4'd6,  OP_LCMP = 4'd7,
    OP_LPOS = 4'd8,  OP_LNEG = 4'd9,  OP_AND  = 4'd10, OP_OR   = 4'd11,
    OP_XOR  = 4'd12, OP_TSEL = 4'd13
  } opCode_e;

  typedef enum logic [2:0] {
    CC_ARITH, CC_CARRY, CC_CMPS, CC_CMPU, CC_BOOL, CC_TSEL
  } ccClass_e;

  typedef enum logic [1:0] { SRC_SUM, SRC_LOAD, SRC_LOGIC } resSrc_e;
  typedef enum logic [1:0] { LD_TEST, LD_COMP, LD_POS, LD_NEG } loadKind_e;
  typedef enum logic [1:0] { LG_AND, LG_OR, LG_XOR } logicFn_e;

  typedef struct packed {
    logic      writeRes;
    logic      writeCc;
    logic      subtract;
    logic      trapable;
    resSrc_e   resSrc;
    loadKind_e loadKind;
    logicFn_e  logicFn;
    ccClass_e  ccClass;
  } ctrlStrobe_t;
endpackage

// File: rtl/fxu_control.sv
module fxu_control
  import fxu_pkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opCode,
  output ctrlStrobe_t ctrl
);
  always_comb begin
    ctrl = '{writeRes: 1'b0, writeCc: 1'b0, subtract: 1'b0, trapable: 1'b0,
             resSrc: SRC_SUM, loadKind: LD_TEST, logicFn: LG_AND, ccClass: CC_ARITH};
    if (opValid) begin
      case (opCode)
        OP_ADD:  begin ctrl.writeRes = 1'b1; ctrl.writeCc = 1'b1; ctrl.trapable = 1'b1; end
        OP_SUB:  begin ctrl.writeRes = 1'b1; ctrl.writeCc = 1'b1; ctrl.trapable = 1'b1;
                       ctrl.subtract = 1'b1; end
        OP_ADDL: begin ctrl.writeRes = 1'b1; ctrl.writeCc = 1'b1; ctrl.ccClass = CC_CARRY; end
        OP_SUBL: begin ctrl.writeRes = 1'b1; ctrl.writeCc = 1'b1; ctrl.ccClass = CC_CARRY;
                       ctrl.subtract = 1'b1; end
        OP_CMP:  begin ctrl.writeCc = 1'b1; ctrl.subtract = 1'b1; ctrl.ccClass = CC_CMPS; end
        OP_CMPL: begin ctrl.writeCc = 1'b1; ctrl.subtract = 1'b1; ctrl.ccClass = CC_CMPU; end
        OP_LTST, OP_LCMP, OP_LPOS, OP_LNEG: begin
          ctrl.writeRes = 1'b1;
          ctrl.writeCc  = 1'b1;
          ctrl.resSrc   = SRC_LOAD;
          ctrl.loadKind = loadKind_e'(opCode[1:0] - 2'd2);
          ctrl.trapable = (opCode == OP_LCMP) || (opCode == OP_LPOS);
        end
        OP_AND, OP_OR, OP_XOR: begin
          ctrl.writeRes = 1'b1;
          ctrl.writeCc  = 1'b1;
          ctrl.resSrc   = SRC_LOGIC;
          ctrl.ccClass  = CC_BOOL;
          ctrl.logicFn  = logicFn_e'(opCode[1:0] - 2'd2);
        end
        OP_TSEL: begin ctrl.writeCc = 1'b1; ctrl.ccClass = CC_TSEL; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fxu_datapath.sv
module fxu_datapath
  import fxu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int SEL_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             progMaskEn,
  output logic [WIDTH-1:0] resReg,
  output logic [1:0]       ccReg,
  output logic             irqReg
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] addend, negB, loadVal, logicVal, resNext, sumLow;
  logic [WIDTH:0]   sum;
  logic             arithOvf, loadOvf, ovf, sumZero;
  logic [SEL_BITS-1:0] selBits, selMask;
  logic [1:0]       ccNext;

  // shared adder: subtract forms A + ~B + 1
  always_comb begin
    addend   = ctrl.subtract ? ~opB : opB;
    sum      = {1'b0, opA} + {1'b0, addend} + {{WIDTH{1'b0}}, ctrl.subtract};
    sumLow   = sum[MSB:0];
    sumZero  = (sumLow == '0);
    arithOvf = (opA[MSB] == addend[MSB]) && (sumLow[MSB] != opA[MSB]);
  end

  always_comb begin
    negB    = '0 - opB;
    loadOvf = 1'b0;
    case (ctrl.loadKind)
      LD_TEST: loadVal = opB;
      LD_COMP: begin loadVal = negB; loadOvf = (opB == MOST_NEG); end
      LD_POS:  begin loadVal = opB[MSB] ? negB : opB; loadOvf = (opB == MOST_NEG); end
      default: loadVal = (opB[MSB] || opB == '0) ? opB : negB;
    endcase
  end

  always_comb begin
    case (ctrl.logicFn)
      LG_AND:  logicVal = opA & opB;
      LG_OR:   logicVal = opA | opB;
      default: logicVal = opA ^ opB;
    endcase
  end

  always_comb begin
    case (ctrl.resSrc)
      SRC_LOAD:  begin resNext = loadVal;  ovf = loadOvf;  end
      SRC_LOGIC: begin resNext = logicVal; ovf = 1'b0;     end
      default:   begin resNext = sumLow;   ovf = arithOvf; end
    endcase
  end

  always_comb begin
    selMask = opB[SEL_BITS-1:0];
    selBits = opA[SEL_BITS-1:0] & selMask;
    case (ctrl.ccClass)
      CC_ARITH: ccNext = ovf ? 2'd3 : (resNext == '0) ? 2'd0 : resNext[MSB] ? 2'd1 : 2'd2;
      CC_CARRY: ccNext = {sum[WIDTH], !sumZero};
      CC_CMPS:  ccNext = sumZero ? 2'd0 : (sumLow[MSB] ^ arithOvf) ? 2'd1 : 2'd2;
      CC_CMPU:  ccNext = sumZero ? 2'd0 : !sum[WIDTH] ? 2'd1 : 2'd2;
      CC_BOOL:  ccNext = {1'b0, resNext != '0};
      default:  ccNext = (selBits == '0) ? 2'd0 : (selBits == selMask) ? 2'd3 : 2'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resReg <= '0;
      ccReg  <= 2'd0;
      irqReg <= 1'b0;
    end else begin
      if (ctrl.writeRes) resReg <= resNext;
      if (ctrl.writeCc)  ccReg  <= ccNext;
      irqReg <= ctrl.trapable && ovf && progMaskEn;
    end
  end

  AST_TRAP_CC3: assert property (@(posedge clk) disable iff (!rstN)
    irqReg |-> ccReg == 2'd3); // R9
  AST_TRAP_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqReg |-> $past(progMaskEn)); // R9
  AST_BOOL_CC: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.writeCc && ctrl.ccClass == CC_BOOL) |=> !ccReg[1]); // R6
  AST_CMP_NO_CC3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.writeCc && (ctrl.ccClass == CC_CMPS || ctrl.ccClass == CC_CMPU)) |=> ccReg != 2'd3); // R4
endmodule

// File: rtl/fxu_branch.sv
module fxu_branch #(
  parameter int CC_BITS = 2
) (
  input  logic [(1<<CC_BITS)-1:0] brMask,
  input  logic [CC_BITS-1:0]      cc,
  output logic                    taken
);
  localparam int TOP_BIT = (1 << CC_BITS) - 1;
  logic [CC_BITS-1:0] bitIdx;

  always_comb begin
    bitIdx = CC_BITS'(TOP_BIT) - cc;
    taken  = brMask[bitIdx];
  end

  always_comb begin
    if (&brMask) AST_MASK_ALL: assert (taken);   // R10
    if (brMask == '0) AST_MASK_NONE: assert (!taken); // R10
  end
endmodule

// File: rtl/fxu_top.sv
module fxu_top
  import fxu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int SEL_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [3:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             progMaskEn,
  input  logic [3:0]       brMask,
  output logic [WIDTH-1:0] result,
  output logic [1:0]       ccOut,
  output logic             ovfIrq,
  output logic             brTaken
);
  ctrlStrobe_t ctrl;

  fxu_control uCtrl (.opValid(opValid), .opCode(opCode), .ctrl(ctrl));

  fxu_datapath #(.WIDTH(WIDTH), .SEL_BITS(SEL_BITS)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .progMaskEn(progMaskEn), .resReg(result), .ccReg(ccOut), .irqReg(ovfIrq));

  fxu_branch #(.CC_BITS(2)) uBr (.brMask(brMask), .cc(ccOut), .taken(brTaken));

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opCode >= 4'd14) |=> ($stable(ccOut) && $stable(result))); // R8
  AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 4'd4 || opCode == 4'd5)) |=> $stable(result)); // R4
  AST_TSEL_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd13) |=> $stable(result)); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> $past(opValid)); // R9
endmodule

// File: tb/fxu_top_test.sv
`timescale 1ns/1ps
module fxu_top_test;
  logic clk = 1'b0;
  logic rstN, opValid, progMaskEn, ovfIrq, brTaken;
  logic [3:0] opCode, brMask;
  logic [31:0] opA, opB, result;
  logic [1:0] ccOut;
  int checks = 0, errors = 0;
  logic [31:0] expRes;
  logic [1:0]  expCc;

  always #4 clk = ~clk;

  fxu_top uut (.clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .progMaskEn(progMaskEn), .brMask(brMask),
    .result(result), .ccOut(ccOut), .ovfIrq(ovfIrq), .brTaken(brTaken));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7, 4'd8, 4'd9: return "R5";
      4'd10, 4'd11, 4'd12: return "R6";
      4'd13: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [1:0] signCc(input logic [31:0] v);
    return (v == 0) ? 2'd0 : v[31] ? 2'd1 : 2'd2;
  endfunction

  // arithmetic reference model updating expected state
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic ovf);
    logic signed [32:0] s;
    logic [32:0] u;
    logic [7:0] sel;
    ovf = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        s = (op == 4'd0) ? $signed({a[31], a}) + $signed({b[31], b})
                         : $signed({a[31], a}) - $signed({b[31], b});
        ovf = s[32] != s[31];
        expRes = s[31:0];
        expCc = ovf ? 2'd3 : signCc(expRes);
      end
      4'd2, 4'd3: begin
        u = (op == 4'd2) ? {1'b0, a} + {1'b0, b} : {1'b0, a} + {1'b0, ~b} + 33'd1;
        expRes = u[31:0];
        expCc = {u[32], u[31:0] != 0};
      end
      4'd4: expCc = (a == b) ? 2'd0 : ($signed(a) < $signed(b)) ? 2'd1 : 2'd2;
      4'd5: expCc = (a == b) ? 2'd0 : (a < b) ? 2'd1 : 2'd2;
      4'd6: begin expRes = b; expCc = signCc(b); end
      4'd7: begin ovf = (b == 32'h8000_0000); expRes = -b;
                  expCc = ovf ? 2'd3 : signCc(expRes); end
      4'd8: begin ovf = (b == 32'h8000_0000); expRes = b[31] ? -b : b;
                  expCc = ovf ? 2'd3 : (expRes == 0) ? 2'd0 : 2'd2; end
      4'd9: begin expRes = ($signed(b) > 0) ? -b : b; expCc = (expRes == 0) ? 2'd0 : 2'd1; end
      4'd10, 4'd11, 4'd12: begin
        expRes = (op == 4'd10) ? (a & b) : (op == 4'd11) ? (a | b) : (a ^ b);
        expCc = (expRes == 0) ? 2'd0 : 2'd1;
      end
      4'd13: begin
        sel = a[7:0] & b[7:0];
        expCc = (sel == 0) ? 2'd0 : (sel == b[7:0]) ? 2'd3 : 2'd1;
      end
      default: ;
    endcase
  endtask

  task automatic doOp(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic en);
    logic ovf;
    @(negedge clk);
    opValid = 1'b1; opCode = op; opA = a; opB = b; progMaskEn = en;
    model(op, a, b, ovf);
    @(negedge clk);
    opValid = 1'b0;
    check({tagOf(op), " result"}, result, expRes);
    check({tagOf(op), " cc"}, {30'd0, ccOut}, {30'd0, expCc});
    check("R9 irq", {31'd0, ovfIrq}, {31'd0, ovf && en});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vals [10];
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
             32'h2, 32'hFFFF_FFFE, 32'h0000_00A5, 32'h0000_005A, 32'h8000_00FF};
    rstN = 1'b0; opValid = 1'b0; opCode = 4'd0; opA = 32'h1234_5678; opB = 32'h9;
    progMaskEn = 1'b1; brMask = 4'h0;
    opValid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 result", result, 32'h0);
    check("R1 cc", {30'd0, ccOut}, 32'h0);
    check("R1 irq", {31'd0, ovfIrq}, 1'b0);
    opValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {30'd0, ccOut}, 32'h0);
    expRes = 32'h0; expCc = 2'd0;

    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          doOp(4'(op), vals[i], vals[j], ((i + j + op) % 2) == 0);

    // overflow with interrupt gating, both settings: R9
    doOp(4'd0, 32'h7FFF_FFFF, 32'h1, 1'b1);
    @(negedge clk);
    check("R9 pulse one cycle", {31'd0, ovfIrq}, 32'h0);
    doOp(4'd8, 32'h0, 32'h8000_0000, 1'b0);
    check("R5 lpos min result", result, 32'h8000_0000);

    // idle cycles hold state: R8
    doOp(4'd12, 32'hF0F0_0000, 32'h0F0F_0001, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 idle result", result, expRes);
    check("R8 idle cc", {30'd0, ccOut}, {30'd0, expCc});

    // branch mask sweep against each code value: R10
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: doOp(4'd0, 32'h0, 32'h0, 1'b0);
        1: doOp(4'd1, 32'h0, 32'h1, 1'b0);
        2: doOp(4'd0, 32'h1, 32'h0, 1'b0);
        default: doOp(4'd0, 32'h7FFF_FFFF, 32'h1, 1'b0);
      endcase
      for (int m = 0; m < 16; m++) begin
        brMask = 4'(m);
        #1;
        check("R10 branch", {31'd0, brTaken}, {31'd0, m[3 - c]});
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule